// File: doc/BRIEF.md
# Address-space-tagged translation buffer

This block caches virtual-to-physical page translations in a fully associative array whose depth is a parameter. Pages are 8 KiB, so the virtual page number (VPN) is the virtual address with its low 13 bits dropped. Each slot holds a VPN tag, a physical page number, an address-space number, a global bit, two per-privilege-mode enable masks (one for reads, one for writes) and two fault-on-access bits.

Lookup is combinational. The requester presents an address and its current address-space number and gets back hit, the slot index and the stored fields. Four commands change the contents on the clock edge: insert a translation, drop everything, drop every non-global translation, and drop the translations of one page for one address space. New translations go into the slots in round-robin order. The default depth of 48 fits an instruction-side instance. A data-side instance sets it to 64.

Top module: `asn_tlb`

## Requirements
- R1: A lookup hits in a slot only when that slot is valid, its tag equals lk_va_i shifted right by 13, and either its global bit is set or its stored address-space number equals lk_asn_i.
- R2: On a miss lk_hit_o is 0, and lk_idx_o, lk_ppn_o, lk_global_o, both mode masks and both fault bits are all 0. On a hit they carry the fields of the hitting slot.
- R3: An insert writes the slot at the replacement pointer, evicting whatever it held. The slot becomes valid with tag ins_va_i shifted right by 13 and the supplied fields.
- R4: The replacement pointer is 0 after reset and after flush-all. It advances by one after each insert that is not dropped, and wraps to 0 after slot ENTRIES-1.
- R5: Flush-all invalidates every slot and clears all of its fields. An insert in the same cycle is dropped.
- R6: Flush-process invalidates every slot whose global bit is clear and keeps the global slots valid.
- R7: Flush-address invalidates every valid slot whose tag equals flush_va_i shifted right by 13 and which is either global or holds flush_asn_i. All other slots stay valid.
- R8: When several slots hit, the lowest index is reported.
- R9: Every command takes effect on the rising clock edge. A lookup in the same cycle sees the contents from before that edge.
- R10: When an insert falls in the same cycle as flush-process or flush-address, the flushes act on the other slots and the newly written slot survives.
- R11: After reset every slot is invalid, so every lookup misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lk_va_i | input | VA_W | Lookup virtual address |
| lk_asn_i | input | ASN_W | Lookup address-space number |
| lk_hit_o | output | 1 | Lookup hit |
| lk_idx_o | output | IDX_W | Index of hitting slot |
| lk_ppn_o | output | PPN_W | Physical page number of hit |
| lk_global_o | output | 1 | Global bit of hit |
| lk_rd_en_o | output | 4 | Per-mode read enable mask of hit |
| lk_wr_en_o | output | 4 | Per-mode write enable mask of hit |
| lk_fault_rd_o | output | 1 | Fault-on-read bit of hit |
| lk_fault_wr_o | output | 1 | Fault-on-write bit of hit |
| ins_valid_i | input | 1 | Insert command |
| ins_va_i | input | VA_W | Insert virtual address |
| ins_ppn_i | input | PPN_W | Insert physical page number |
| ins_asn_i | input | ASN_W | Insert address-space number |
| ins_global_i | input | 1 | Insert global bit |
| ins_rd_en_i | input | 4 | Insert read enable mask |
| ins_wr_en_i | input | 4 | Insert write enable mask |
| ins_fault_rd_i | input | 1 | Insert fault-on-read bit |
| ins_fault_wr_i | input | 1 | Insert fault-on-write bit |
| flush_all_i | input | 1 | Invalidate every slot |
| flush_proc_i | input | 1 | Invalidate every non-global slot |
| flush_addr_i | input | 1 | Invalidate the matching page |
| flush_va_i | input | VA_W | Flush-address virtual address |
| flush_asn_i | input | ASN_W | Flush-address address-space number |

## Verification
An insert and a flush can land in the same cycle, and so can a command and a lookup of the slot it changes. Random stimulus draws insert, both selective flushes and flush-all independently each cycle, over a small set of pages and address-space numbers, so overlaps come up often. Directed cycles pair an insert with flush-process and with flush-all. The lookup is sampled before the edge, where it must show the old contents, and again in the following cycle, where it is compared against a bench model that applies flush-all first, then the insert to its slot, then the selective flushes to the remaining slots.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int unsigned NUM_MODES = 4;
  typedef logic [NUM_MODES-1:0] mode_mask_t;
  typedef struct packed {
    mode_mask_t rd_en;
    mode_mask_t wr_en;
    logic       fault_rd;
    logic       fault_wr;
  } perm_t;
endpackage

// File: rtl/tlb_entry.sv
module tlb_entry
  import tlb_pkg::*;
#(
  parameter int unsigned VPN_W = 30,
  parameter int unsigned PPN_W = 28,
  parameter int unsigned ASN_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [VPN_W-1:0] lk_vpn_i,
  input  logic [ASN_W-1:0] lk_asn_i,
  input  logic [VPN_W-1:0] fl_vpn_i,
  input  logic [ASN_W-1:0] fl_asn_i,
  input  logic             flush_all_i,
  input  logic             flush_proc_i,
  input  logic             flush_addr_i,
  input  logic             load_i,
  input  logic [VPN_W-1:0] ld_vpn_i,
  input  logic [PPN_W-1:0] ld_ppn_i,
  input  logic [ASN_W-1:0] ld_asn_i,
  input  logic             ld_global_i,
  input  perm_t            ld_perm_i,
  output logic             valid_o,
  output logic             hit_o,
  output logic [PPN_W-1:0] ppn_o,
  output logic             global_o,
  output perm_t            perm_o
);
  logic             valid_q, glb_q;
  logic [VPN_W-1:0] vpn_q;
  logic [PPN_W-1:0] ppn_q;
  logic [ASN_W-1:0] asn_q;
  perm_t            perm_q;
  logic             fl_hit, kill;

  assign hit_o  = valid_q && (vpn_q == lk_vpn_i) && (glb_q || (asn_q == lk_asn_i));
  assign fl_hit = valid_q && (vpn_q == fl_vpn_i) && (glb_q || (asn_q == fl_asn_i));
  assign kill   = (flush_proc_i && !glb_q) || (flush_addr_i && fl_hit);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      glb_q   <= 1'b0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      asn_q   <= '0;
      perm_q  <= '0;
    end else if (flush_all_i) begin
      valid_q <= 1'b0;
      glb_q   <= 1'b0;
      vpn_q   <= '0;
      ppn_q   <= '0;
      asn_q   <= '0;
      perm_q  <= '0;
    end else if (load_i) begin
      valid_q <= 1'b1;
      glb_q   <= ld_global_i;
      vpn_q   <= ld_vpn_i;
      ppn_q   <= ld_ppn_i;
      asn_q   <= ld_asn_i;
      perm_q  <= ld_perm_i;
    end else if (kill) begin
      valid_q <= 1'b0;
    end
  end

  assign valid_o  = valid_q;
  assign ppn_o    = ppn_q;
  assign global_o = glb_q;
  assign perm_o   = perm_q;

  p_flush_all_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (!valid_q && perm_q == '0 && ppn_q == '0));
  p_load_sets_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && !flush_all_i) |=> (valid_q && vpn_q == $past(ld_vpn_i) && ppn_q == $past(ld_ppn_i)));
  p_proc_keeps_global_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_proc_i && !flush_all_i && !load_i && !flush_addr_i && valid_q && glb_q) |=> valid_q);
  p_addr_kills_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_addr_i && !flush_all_i && !load_i && fl_hit) |=> !valid_q);
endmodule

// File: rtl/tlb_rr_ptr.sv
module tlb_rr_ptr #(
  parameter int unsigned DEPTH = 48,
  localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             adv_i,
  input  logic             clr_i,
  output logic [IDX_W-1:0] ptr_o
);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(DEPTH - 1);
  logic [IDX_W-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      ptr_q <= '0;
    else if (clr_i)   ptr_q <= '0;
    else if (adv_i)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assign ptr_o = ptr_q;

  p_wrap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && ptr_q == LAST) |=> ptr_q == '0);
  p_step_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !clr_i && ptr_q != LAST) |=> ptr_q == $past(ptr_q) + 1'b1);
  p_clr_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> ptr_q == '0);
  p_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!adv_i && !clr_i) |=> $stable(ptr_q));
endmodule

// File: rtl/tlb_first_set.sv
module tlb_first_set #(
  parameter int unsigned N = 48,
  localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [N-1:0]     req_i,
  output logic             any_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end
  assign any_o = |req_i;

  logic [N-1:0] below;
  assign below = (N'(1) << idx_o) - N'(1);

  always_comb begin
    if (any_o) begin
      p_sel_set_r8: assert (req_i[idx_o]);
      p_sel_lowest_r8: assert ((req_i & below) == '0);
    end
  end
endmodule

// File: rtl/asn_tlb.sv
module asn_tlb
  import tlb_pkg::*;
#(
  parameter int unsigned ENTRIES   = 48,
  parameter int unsigned VA_W      = 43,
  parameter int unsigned PAGE_BITS = 13,
  parameter int unsigned PPN_W     = 28,
  parameter int unsigned ASN_W     = 8,
  localparam int unsigned IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [VA_W-1:0]      lk_va_i,
  input  logic [ASN_W-1:0]     lk_asn_i,
  output logic                 lk_hit_o,
  output logic [IDX_W-1:0]     lk_idx_o,
  output logic [PPN_W-1:0]     lk_ppn_o,
  output logic                 lk_global_o,
  output logic [NUM_MODES-1:0] lk_rd_en_o,
  output logic [NUM_MODES-1:0] lk_wr_en_o,
  output logic                 lk_fault_rd_o,
  output logic                 lk_fault_wr_o,
  input  logic                 ins_valid_i,
  input  logic [VA_W-1:0]      ins_va_i,
  input  logic [PPN_W-1:0]     ins_ppn_i,
  input  logic [ASN_W-1:0]     ins_asn_i,
  input  logic                 ins_global_i,
  input  logic [NUM_MODES-1:0] ins_rd_en_i,
  input  logic [NUM_MODES-1:0] ins_wr_en_i,
  input  logic                 ins_fault_rd_i,
  input  logic                 ins_fault_wr_i,
  input  logic                 flush_all_i,
  input  logic                 flush_proc_i,
  input  logic                 flush_addr_i,
  input  logic [VA_W-1:0]      flush_va_i,
  input  logic [ASN_W-1:0]     flush_asn_i
);
  localparam int unsigned VPN_W = VA_W - PAGE_BITS;

  logic [VPN_W-1:0] lk_vpn, ins_vpn, fl_vpn;
  assign lk_vpn  = lk_va_i[VA_W-1:PAGE_BITS];
  assign ins_vpn = ins_va_i[VA_W-1:PAGE_BITS];
  assign fl_vpn  = flush_va_i[VA_W-1:PAGE_BITS];

  perm_t ins_perm;
  assign ins_perm = '{rd_en: ins_rd_en_i, wr_en: ins_wr_en_i,
                      fault_rd: ins_fault_rd_i, fault_wr: ins_fault_wr_i};

  logic [IDX_W-1:0] ptr;
  logic             ins_go;
  assign ins_go = ins_valid_i && !flush_all_i;

  tlb_rr_ptr #(.DEPTH(ENTRIES)) u_ptr (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .adv_i (ins_go),
    .clr_i (flush_all_i),
    .ptr_o (ptr)
  );

  logic [ENTRIES-1:0] load_vec, hit_vec, valid_vec, glb_vec;
  logic [PPN_W-1:0]   ppn_arr  [ENTRIES];
  perm_t              perm_arr [ENTRIES];

  for (genvar g = 0; g < ENTRIES; g++) begin : g_slot
    assign load_vec[g] = ins_go && (ptr == IDX_W'(g));
    tlb_entry #(.VPN_W(VPN_W), .PPN_W(PPN_W), .ASN_W(ASN_W)) u_ent (
      .clk_i       (clk_i),
      .rst_ni      (rst_ni),
      .lk_vpn_i    (lk_vpn),
      .lk_asn_i    (lk_asn_i),
      .fl_vpn_i    (fl_vpn),
      .fl_asn_i    (flush_asn_i),
      .flush_all_i (flush_all_i),
      .flush_proc_i(flush_proc_i),
      .flush_addr_i(flush_addr_i),
      .load_i      (load_vec[g]),
      .ld_vpn_i    (ins_vpn),
      .ld_ppn_i    (ins_ppn_i),
      .ld_asn_i    (ins_asn_i),
      .ld_global_i (ins_global_i),
      .ld_perm_i   (ins_perm),
      .valid_o     (valid_vec[g]),
      .hit_o       (hit_vec[g]),
      .ppn_o       (ppn_arr[g]),
      .global_o    (glb_vec[g]),
      .perm_o      (perm_arr[g])
    );
  end

  logic             any_hit;
  logic [IDX_W-1:0] hit_idx;

  tlb_first_set #(.N(ENTRIES)) u_sel (
    .req_i(hit_vec),
    .any_o(any_hit),
    .idx_o(hit_idx)
  );

  perm_t sel_perm;
  always_comb begin
    lk_hit_o    = any_hit;
    lk_idx_o    = '0;
    lk_ppn_o    = '0;
    lk_global_o = 1'b0;
    sel_perm    = '0;
    if (any_hit) begin
      lk_idx_o    = hit_idx;
      lk_ppn_o    = ppn_arr[hit_idx];
      lk_global_o = glb_vec[hit_idx];
      sel_perm    = perm_arr[hit_idx];
    end
  end
  assign lk_rd_en_o    = sel_perm.rd_en;
  assign lk_wr_en_o    = sel_perm.wr_en;
  assign lk_fault_rd_o = sel_perm.fault_rd;
  assign lk_fault_wr_o = sel_perm.fault_wr;

  p_one_load_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(load_vec));
  p_flush_all_empty_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_all_i |=> (valid_vec == '0 && !lk_hit_o));
  p_proc_clears_local_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flush_proc_i && !ins_valid_i) |=> ((valid_vec & ~glb_vec) == '0));
  p_insert_lands_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ins_go |=> valid_vec[$past(ptr)]);
endmodule

// File: tb/asn_tlb_tb.sv
module asn_tlb_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N     = 8;
  localparam int VA_W  = 43;
  localparam int PB    = 13;
  localparam int PPN_W = 28;
  localparam int ASN_W = 8;
  localparam int IDX_W = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [VA_W-1:0]  lk_va, ins_va, fl_va;
  logic [ASN_W-1:0] lk_asn, ins_asn, fl_asn;
  logic             lk_hit, lk_glb, lk_frd, lk_fwr;
  logic [IDX_W-1:0] lk_idx;
  logic [PPN_W-1:0] lk_ppn, ins_ppn;
  logic [3:0]       lk_rd, lk_wr, ins_rd, ins_wr;
  logic             ins_v, ins_glb, ins_frd, ins_fwr, f_all, f_proc, f_addr;

  asn_tlb #(.ENTRIES(N), .VA_W(VA_W), .PAGE_BITS(PB), .PPN_W(PPN_W), .ASN_W(ASN_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .lk_va_i(lk_va), .lk_asn_i(lk_asn),
    .lk_hit_o(lk_hit), .lk_idx_o(lk_idx), .lk_ppn_o(lk_ppn), .lk_global_o(lk_glb),
    .lk_rd_en_o(lk_rd), .lk_wr_en_o(lk_wr), .lk_fault_rd_o(lk_frd), .lk_fault_wr_o(lk_fwr),
    .ins_valid_i(ins_v), .ins_va_i(ins_va), .ins_ppn_i(ins_ppn), .ins_asn_i(ins_asn),
    .ins_global_i(ins_glb), .ins_rd_en_i(ins_rd), .ins_wr_en_i(ins_wr),
    .ins_fault_rd_i(ins_frd), .ins_fault_wr_i(ins_fwr),
    .flush_all_i(f_all), .flush_proc_i(f_proc), .flush_addr_i(f_addr),
    .flush_va_i(fl_va), .flush_asn_i(fl_asn)
  );

  // bench model
  bit          m_v   [N];
  bit          m_g   [N];
  int unsigned m_vpn [N];
  int unsigned m_ppn [N];
  int unsigned m_asn [N];
  bit [9:0]    m_pm  [N];
  int          m_ptr;

  int tests = 0, fails = 0;
  bit done = 0;

  function automatic logic [VA_W-1:0] mk_va(int unsigned page, int unsigned ofs);
    return (VA_W'(page) << PB) | VA_W'(ofs[PB-1:0]);
  endfunction

  function automatic int exp_idx(int unsigned vpn, int unsigned asn);
    for (int i = 0; i < N; i++)
      if (m_v[i] && m_vpn[i] == vpn && (m_g[i] || m_asn[i] == asn)) return i;
    return -1;
  endfunction

  task automatic idle();
    ins_v = 0; f_all = 0; f_proc = 0; f_addr = 0;
  endtask

  task automatic do_ins(int unsigned page, int unsigned asn, bit g, int unsigned ppn, bit [9:0] pm);
    ins_v = 1; ins_va = mk_va(page, $urandom); ins_asn = ASN_W'(asn); ins_glb = g;
    ins_ppn = PPN_W'(ppn); {ins_rd, ins_wr, ins_frd, ins_fwr} = pm;
  endtask

  task automatic set_lk(int unsigned page, int unsigned asn);
    lk_va = mk_va(page, $urandom); lk_asn = ASN_W'(asn);
  endtask

  // check lookup against model (pre-edge state), then clock and update model
  task automatic step(string tag);
    int e;
    bit [PPN_W-1:0] x_ppn;
    bit [9:0] x_pm;
    bit x_g;
    int x_idx;
    #1;
    e = exp_idx(int'(lk_va >> PB), int'(lk_asn));
    x_idx = (e < 0) ? 0 : e;
    x_ppn = (e < 0) ? '0 : PPN_W'(m_ppn[e]);
    x_pm  = (e < 0) ? '0 : m_pm[e];
    x_g   = (e < 0) ? 1'b0 : m_g[e];
    tests++;
    if (lk_hit !== (e >= 0) || lk_idx !== IDX_W'(x_idx) || lk_ppn !== x_ppn ||
        {lk_rd, lk_wr, lk_frd, lk_fwr} !== x_pm || lk_glb !== x_g) begin
      fails++;
      $display("FAIL %s: hit=%0b idx=%0d ppn=%0h pm=%0h g=%0b exp hit=%0b idx=%0d ppn=%0h pm=%0h g=%0b",
               tag, lk_hit, lk_idx, lk_ppn, {lk_rd, lk_wr, lk_frd, lk_fwr}, lk_glb,
               e >= 0, x_idx, x_ppn, x_pm, x_g);
    end
    @(posedge clk);
    if (f_all) begin
      for (int i = 0; i < N; i++) begin
        m_v[i] = 0; m_g[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asn[i] = 0; m_pm[i] = 0;
      end
      m_ptr = 0;
    end else begin
      for (int i = 0; i < N; i++) begin
        if (ins_v && i == m_ptr) begin
          m_v[i] = 1; m_g[i] = ins_glb; m_vpn[i] = int'(ins_va >> PB);
          m_ppn[i] = int'(ins_ppn); m_asn[i] = int'(ins_asn);
          m_pm[i] = {ins_rd, ins_wr, ins_frd, ins_fwr};
        end else if (m_v[i] && ((f_proc && !m_g[i]) ||
                 (f_addr && m_vpn[i] == int'(fl_va >> PB) && (m_g[i] || m_asn[i] == int'(fl_asn)))))
          m_v[i] = 0;
      end
      if (ins_v) m_ptr = (m_ptr + 1) % N;
    end
    @(negedge clk);
    idle();
  endtask

  initial begin
    for (int i = 0; i < N; i++) begin
      m_v[i] = 0; m_g[i] = 0; m_vpn[i] = 0; m_ppn[i] = 0; m_asn[i] = 0; m_pm[i] = 0;
    end
    m_ptr = 0;
    void'($urandom(32'd2024));
    idle();
    lk_va = '0; lk_asn = '0; ins_va = '0; ins_asn = '0; ins_ppn = '0; ins_glb = 0;
    ins_rd = 0; ins_wr = 0; ins_frd = 0; ins_fwr = 0; fl_va = '0; fl_asn = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    set_lk(1, 1); step("R11 R2 reset miss");
    // fill every slot, lookup of the page being inserted must miss this cycle
    for (int i = 0; i < N; i++) begin
      do_ins(i + 1, 1, 0, 100 + i, 10'(i * 37 + 5));
      set_lk(i + 1, 1);
      step("R9 R3 same-cycle insert");
    end
    for (int i = 0; i < N; i++) begin
      set_lk(i + 1, 1); step("R3 R1 R2 hit fields");
    end
    set_lk(3, 2); step("R1 asn mismatch");
    // ninth insert wraps to slot 0
    do_ins(20, 1, 0, 500, 10'h2aa); set_lk(1, 1); step("R4 wrap insert");
    set_lk(1, 1); step("R4 evicted");
    set_lk(20, 1); step("R4 R3 slot 0");
    // two global copies: lowest index wins
    do_ins(30, 5, 1, 600, 10'h155); step("R8 ins a");
    do_ins(30, 6, 1, 601, 10'h0f0); step("R8 ins b");
    set_lk(30, 7); step("R8 lowest index");
    // flush-process keeps globals
    f_proc = 1; set_lk(5, 1); step("R9 R6 flush proc");
    set_lk(5, 1); step("R6 local gone");
    set_lk(30, 2); step("R6 global kept");
    // flush-address
    do_ins(9, 3, 0, 700, 10'h3c3); step("R7 ins");
    f_addr = 1; fl_va = mk_va(9, 0); fl_asn = 2; set_lk(9, 3); step("R7 wrong asn");
    set_lk(9, 3); step("R7 survives");
    f_addr = 1; fl_va = mk_va(9, 77); fl_asn = 3; step("R7 right asn");
    set_lk(9, 3); step("R7 gone");
    f_addr = 1; fl_va = mk_va(30, 0); fl_asn = 0; step("R7 global");
    set_lk(30, 5); step("R7 global gone");
    // insert with flush-process in same cycle
    do_ins(11, 4, 0, 800, 10'h111); f_proc = 1; step("R10 ins+proc");
    set_lk(11, 4); step("R10 new survives");
    // insert with flush-all: insert dropped, pointer to 0
    do_ins(12, 4, 1, 900, 10'h222); f_all = 1; set_lk(11, 4); step("R10 R5 ins+all");
    set_lk(12, 4); step("R5 dropped");
    set_lk(11, 4); step("R5 cleared");
    do_ins(13, 0, 0, 901, 10'h333); step("R4 after flush");
    set_lk(13, 0); step("R4 ptr zero");

    // random mix
    for (int k = 0; k < 600; k++) begin
      int r;
      r = int'($urandom % 100);
      if (r < 35) do_ins($urandom % 6, $urandom % 4, ($urandom % 4) == 0,
                         $urandom % 4096, 10'($urandom));
      if (($urandom % 100) < 5) f_proc = 1;
      if (($urandom % 100) < 12) begin
        f_addr = 1; fl_va = mk_va($urandom % 6, $urandom); fl_asn = ASN_W'($urandom % 4);
      end
      if (($urandom % 100) < 2) f_all = 1;
      set_lk($urandom % 6, $urandom % 4);
      step("R1 R3 R6 R7 R8 R10 random");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule